// File: doc/BRIEF.md
# Load/Store Pipe Interlock Controller

This block decides, every cycle, which ops in a four-stage load/store pipe move forward and which wait. The stages are indexed 0 to 3: 0 is dispatch, 1 is address generation, 2 is cache read and 3 is writeback. The controller keeps its own record of which stage is occupied and which class of op sits in it. An op is offered at dispatch with a class code. The controller applies three interlocks: an operand-ready wait, a one-at-a-time rule for reservation ops and a drain rule for barriers. Any hold ripples back to the earlier stages, and a stage that receives nothing for a cycle is flagged as a bubble.

Leaving writeback needs an external commit pulse. Writeback is run by a three-state machine. WB_EMPTY holds no op. WB_SETTLE is the extra first cycle of a floating-point load. WB_RETIRE holds an op that may leave on commit. Its transitions are:
- fill: WB_EMPTY to WB_SETTLE for a floating-point load, or to WB_RETIRE for any other class.
- settle-done: WB_SETTLE to WB_RETIRE, unconditionally.
- retire: WB_RETIRE to WB_EMPTY on commit.
- retire-and-refill: WB_RETIRE to WB_SETTLE or WB_RETIRE on commit, when an op enters in the same cycle.
- wait: WB_RETIRE stays in WB_RETIRE without commit.

Datapaths, addresses and cache contents belong to other blocks.

Top module: `ls_pipe_interlock`

## Requirements
- R1: Class codes are 0 integer load, 1 floating-point load, 2 store, 3 reservation (load-reserve or store-conditional), 4 barrier. Codes 5 to 7 act as a general op that needs operands and yields no load data.
- R2: An op in stage 0 whose class is neither store nor barrier does not advance while `src_ready` is low, and `stage_hold[0]` is high.
- R3: A store leaves stage 0 regardless of `src_ready`. It holds in stage 1 while `st_data_ready` is low.
- R4: A reservation op in stage 0 holds while a reservation op occupies stage 1, 2 or 3. At most one reservation op is ever past stage 0.
- R5: While a barrier occupies stage 1, 2 or 3, no op leaves stage 0, which keeps stages 1 and 2 empty behind it. A barrier in stage 3 retires only when stages 1 and 2 are empty.
- R6: An op leaves stage 3 only in a cycle with `commit` high. `commit` has no effect when stage 3 is empty or when its op is not yet eligible.
- R7: `load_data_valid` pulses in the cycle a class 0 or class 1 op leaves stage 3. A floating-point load stays at least two cycles in stage 3. With no stalls and `commit` high, load data is ready 3 cycles after entry to stage 1 for an integer load and 4 cycles for a floating-point load.
- R8: An occupied stage whose successor is not freed this cycle holds. A hold therefore propagates to every earlier occupied stage.
- R9: `stage_bubble[k]` is high when stage k will be empty after the clock edge. `issue_accept` is high exactly when an offered op enters stage 0, which happens when stage 0 is empty or advancing.
- R10: Reset empties every stage, so no reservation or barrier flag survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An op is offered at dispatch |
| issue_class | input | 3 | Class code of the offered op |
| src_ready | input | 1 | Source operands of the op in stage 0 are ready |
| st_data_ready | input | 1 | Store data for the op in stage 1 is ready |
| commit | input | 1 | Retire request for the op in stage 3 |
| issue_accept | output | 1 | Offered op is taken this cycle |
| stage_busy | output | 4 | Occupancy per stage |
| stage_hold | output | 4 | Stage occupied and not moving on |
| stage_adv | output | 4 | Stage op moves on at the clock edge |
| stage_bubble | output | 4 | Stage will be empty after the edge |
| load_data_valid | output | 1 | Load data leaves writeback this cycle |

## Verification
A wrong occupancy or class record shows at the ports in the same cycle. `stage_busy` and `stage_adv` change together, a held op shows up in `stage_hold`, and a missing hold shows up as an `stage_adv` bit one cycle too early. A writeback state stuck in WB_SETTLE or skipping it moves `load_data_valid` by exactly one cycle, which the latency checks measure. A lost reservation or barrier flag lets stage 0 advance in a cycle where the reference model expects a hold, so the first divergence is seen on the next compared clock.

// File: rtl/lspi_pkg.sv
`timescale 1ns/1ps
package lspi_pkg;
    localparam int CLS_W = 3;
    localparam int NSTG  = 4;
    localparam int S_DSP = 0;
    localparam int S_AG  = 1;
    localparam int S_CR  = 2;
    localparam int S_WB  = NSTG - 1;

    typedef enum logic [CLS_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_FLOAD = 3'd1,
        OP_STORE = 3'd2,
        OP_RESV  = 3'd3,
        OP_BARR  = 3'd4
    } op_cls_e;

    typedef enum logic [1:0] {
        WB_EMPTY  = 2'd0,
        WB_SETTLE = 2'd1,
        WB_RETIRE = 2'd2
    } wb_st_e;
endpackage

// File: rtl/lspi_stage.sv
`timescale 1ns/1ps
module lspi_stage
    import lspi_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_i,
    input  logic    leave_i,
    input  op_cls_e cls_i,
    output logic    busy_o,
    output op_cls_e cls_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cls_o  <= OP_LOAD;
        end else if (load_i) begin
            busy_o <= 1'b1;
            cls_o  <= cls_i;
        end else if (leave_i) begin
            busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/lspi_wb_ctrl.sv
`timescale 1ns/1ps
module lspi_wb_ctrl
    import lspi_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    take_i,
    input  op_cls_e cls_i,
    input  logic    commit_i,
    input  logic    drain_ok_i,
    output logic    busy_o,
    output op_cls_e cls_o,
    output logic    leave_o
);
    wb_st_e state_q, state_d, entry_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WB_EMPTY;
            cls_o   <= OP_LOAD;
        end else begin
            state_q <= state_d;
            if (take_i) cls_o <= cls_i;
        end
    end

    always_comb begin
        entry_st = (cls_i == OP_FLOAD) ? WB_SETTLE : WB_RETIRE;
        state_d  = state_q;
        unique case (state_q)
            WB_EMPTY:  state_d = take_i ? entry_st : WB_EMPTY;
            WB_SETTLE: state_d = WB_RETIRE;
            WB_RETIRE: if (leave_o) state_d = take_i ? entry_st : WB_EMPTY;
            default:   state_d = WB_EMPTY;
        endcase
    end

    always_comb begin
        leave_o = 1'b0;
        unique case (state_q)
            WB_RETIRE: leave_o = commit_i & ((cls_o != OP_BARR) | drain_ok_i);
            default:   leave_o = 1'b0;
        endcase
        busy_o = (state_q != WB_EMPTY);
    end
endmodule

// File: rtl/ls_pipe_interlock.sv
`timescale 1ns/1ps
module ls_pipe_interlock
    import lspi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [CLS_W-1:0] issue_class,
    input  logic             src_ready,
    input  logic             st_data_ready,
    input  logic             commit,
    output logic             issue_accept,
    output logic [NSTG-1:0]  stage_busy,
    output logic [NSTG-1:0]  stage_hold,
    output logic [NSTG-1:0]  stage_adv,
    output logic [NSTG-1:0]  stage_bubble,
    output logic             load_data_valid
);
    op_cls_e [NSTG-1:0] stage_cls;
    op_cls_e [NSTG-1:0] stg_in;
    logic    [NSTG-1:0] stg_load;
    logic    [NSTG-1:0] stg_free;
    logic    [NSTG-1:0] stg_block;
    logic               resv_ahead, barr_ahead, needs_opnd, wb_leave;

    // stages 0..NSTG-2 are plain occupancy registers
    for (genvar k = 0; k < NSTG - 1; k++) begin : g_stage
        lspi_stage u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (stg_load[k]),
            .leave_i (stage_adv[k]),
            .cls_i   (stg_in[k]),
            .busy_o  (stage_busy[k]),
            .cls_o   (stage_cls[k])
        );
    end

    lspi_wb_ctrl u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (stg_load[S_WB]),
        .cls_i      (stg_in[S_WB]),
        .commit_i   (commit),
        .drain_ok_i (!stage_busy[S_AG] && !stage_busy[S_CR]),
        .busy_o     (stage_busy[S_WB]),
        .cls_o      (stage_cls[S_WB]),
        .leave_o    (wb_leave)
    );

    // hazard detection and advance chain
    always_comb begin
        resv_ahead = 1'b0;
        barr_ahead = 1'b0;
        for (int k = S_AG; k < NSTG; k++) begin
            if (stage_busy[k] && stage_cls[k] == OP_RESV) resv_ahead = 1'b1;
            if (stage_busy[k] && stage_cls[k] == OP_BARR) barr_ahead = 1'b1;
        end
        needs_opnd = (stage_cls[S_DSP] != OP_STORE) && (stage_cls[S_DSP] != OP_BARR);

        stg_block        = '0;
        stg_block[S_DSP] = (needs_opnd && !src_ready)
                         || (stage_cls[S_DSP] == OP_RESV && resv_ahead)
                         || barr_ahead;
        stg_block[S_AG]  = (stage_cls[S_AG] == OP_STORE) && !st_data_ready;

        stage_adv[S_WB] = wb_leave;
        stg_free[S_WB]  = !stage_busy[S_WB] || wb_leave;
        for (int k = NSTG - 2; k >= 0; k--) begin
            stage_adv[k] = stage_busy[k] && !stg_block[k] && stg_free[k+1];
            stg_free[k]  = !stage_busy[k] || stage_adv[k];
        end

        issue_accept    = issue_valid && stg_free[S_DSP];
        stg_load[S_DSP] = issue_accept;
        stg_in[S_DSP]   = op_cls_e'(issue_class);
        for (int k = 1; k < NSTG; k++) begin
            stg_load[k] = stage_adv[k-1];
            stg_in[k]   = stage_cls[k-1];
        end

        stage_hold      = stage_busy & ~stage_adv;
        stage_bubble    = stg_free & ~stg_load;
        load_data_valid = wb_leave && (stage_cls[S_WB] == OP_LOAD
                                    || stage_cls[S_WB] == OP_FLOAD);
    end
endmodule

// File: rtl/lspi_checker.sv
`timescale 1ns/1ps
module lspi_checker
    import lspi_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               commit,
    input logic               src_ready,
    input logic               st_data_ready,
    input logic [NSTG-1:0]    busy,
    input logic [NSTG-1:0]    hold,
    input logic [NSTG-1:0]    adv,
    input op_cls_e [NSTG-1:0] cls
);
    a_r1_adv_fills_next: assert property (@(posedge clk) disable iff (!rst_n)
        adv[S_AG] |=> busy[S_CR]);

    a_r2_operand_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[S_DSP] && cls[S_DSP] != OP_STORE && cls[S_DSP] != OP_BARR && !src_ready)
        |-> !adv[S_DSP]);

    a_r3_store_waits_ag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[S_AG] && cls[S_AG] == OP_STORE && !st_data_ready) |-> !adv[S_AG]);

    a_r4_single_resv: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy[S_AG] && cls[S_AG] == OP_RESV,
                    busy[S_CR] && cls[S_CR] == OP_RESV,
                    busy[S_WB] && cls[S_WB] == OP_RESV}) <= 1);

    a_r5_barrier_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy[S_AG] && cls[S_AG] == OP_BARR) || (busy[S_CR] && cls[S_CR] == OP_BARR)
         || (busy[S_WB] && cls[S_WB] == OP_BARR)) |-> !adv[S_DSP]);

    a_r6_commit_needed: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> !adv[S_WB]);

    a_r7_fp_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (adv[S_CR] && cls[S_CR] == OP_FLOAD) |=> !adv[S_WB]);

    a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[S_CR] && busy[S_AG]) |-> hold[S_AG]);
endmodule

bind ls_pipe_interlock lspi_checker u_lspi_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .src_ready     (src_ready),
    .st_data_ready (st_data_ready),
    .busy          (stage_busy),
    .hold          (stage_hold),
    .adv           (stage_adv),
    .cls           (stage_cls)
);

// File: tb/test_ls_pipe_interlock.sv
`timescale 1ns/1ps
module test_ls_pipe_interlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [2:0] issue_class = 3'd0;
    logic       src_ready = 1'b0, st_data_ready = 1'b0, commit = 1'b0;
    logic       issue_accept, load_data_valid;
    logic [3:0] stage_busy, stage_hold, stage_adv, stage_bubble;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    bit [3:0] mv;
    int       mc [4];
    bit       m_wb_new;

    always #2.5 clk = ~clk;

    ls_pipe_interlock i_ls_pipe_interlock (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        mv = '0; m_wb_new = 0;
        foreach (mc[k]) mc[k] = 0;
    endtask

    // one clock: drive, compare against the model, then advance the model
    task automatic cyc(bit iv, int ic, bit sr, bit sd, bit cm);
        bit [3:0] ea, ef, ent, eb;
        bit ra, ba, s0, s1, acc, ldv;
        @(negedge clk);
        issue_valid = iv; issue_class = 3'(ic);
        src_ready = sr; st_data_ready = sd; commit = cm;
        #1;
        ra = 0; ba = 0;
        for (int k = 1; k < 4; k++) begin
            if (mv[k] && mc[k] == 3) ra = 1;
            if (mv[k] && mc[k] == 4) ba = 1;
        end
        ea[3] = mv[3] && cm && !(mc[3] == 1 && m_wb_new) && !(mc[3] == 4 && (mv[1] || mv[2]));
        ef[3] = !mv[3] || ea[3];
        ea[2] = mv[2] && ef[3];
        ef[2] = !mv[2] || ea[2];
        s1 = (mc[1] == 2) && !sd;
        ea[1] = mv[1] && !s1 && ef[2];
        ef[1] = !mv[1] || ea[1];
        s0 = (mc[0] != 2 && mc[0] != 4 && !sr) || (mc[0] == 3 && ra) || ba;
        ea[0] = mv[0] && !s0 && ef[1];
        ef[0] = !mv[0] || ea[0];
        acc = iv && ef[0];
        ent = {ea[2], ea[1], ea[0], acc};
        eb = ef & ~ent;
        ldv = ea[3] && (mc[3] == 0 || mc[3] == 1);
        chk("R1 busy", stage_busy, mv);
        chk("R1 adv", stage_adv, ea);
        chk("R9 accept", issue_accept, acc);
        chk("R8 hold", stage_hold, mv & ~ea);
        chk("R9 bubble", stage_bubble, eb);
        chk("R7 ldv", load_data_valid, ldv);
        @(posedge clk);
        if (ea[3]) mv[3] = 0;
        for (int k = 3; k >= 1; k--)
            if (ea[k-1]) begin mv[k] = 1; mc[k] = mc[k-1]; mv[k-1] = 0; end
        if (acc) begin mv[0] = 1; mc[0] = ic; end
        m_wb_new = ea[2];
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        issue_valid = 0; commit = 0;
        @(posedge clk); @(posedge clk); #1;
        model_clear();
        chk("R10 reset empty", stage_busy, 0);
        chk("R10 reset no data", load_data_valid, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic flush();
        for (int i = 0; i < 20 && mv != 0; i++) cyc(0, 0, 1, 1, 1);
    endtask

    task automatic latency(int cls, int exp_lat, string tag);
        int n;
        cyc(1, cls, 1, 1, 1);
        n = 0;
        for (int i = 0; i < 10 && !load_data_valid; i++) begin
            cyc(0, 0, 1, 1, 1); n++;
        end
        chk(tag, n, exp_lat);
        flush();
    endtask

    initial begin
        model_clear();
        do_reset();

        // R7: three cycles after stage 1 entry for integer, four for floating point
        latency(0, 4, "R7 int load latency");
        latency(1, 5, "R7 fp load latency");

        // R2: operand wait in dispatch, and a bubble into stage 1
        cyc(1, 0, 0, 1, 1);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 1, 1);
            chk("R2 hold dispatch", stage_hold[0], 1);
            chk("R9 bubble stage1", stage_bubble[1], 1);
        end
        cyc(0, 0, 1, 1, 1);
        chk("R2 release", stage_adv[0], 1);
        flush();

        // R3: store ignores src_ready, waits for store data in stage 1
        cyc(1, 2, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R3 store leaves dispatch", stage_adv[0], 1);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0, 1);
            chk("R3 store holds in stage1", stage_hold[1], 1);
        end
        cyc(0, 0, 0, 1, 1);
        chk("R3 store data release", stage_adv[1], 1);
        flush();

        // R4: second reservation op waits for the first to commit
        cyc(1, 3, 1, 1, 0);
        cyc(1, 3, 1, 1, 0);
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 1, 1, 0);
            chk("R4 resv held", stage_hold[0], 1);
        end
        cyc(0, 0, 1, 1, 1);
        chk("R4 first retires", stage_adv[3], 1);
        chk("R4 second still held", stage_hold[0], 1);
        cyc(0, 0, 1, 1, 0);
        chk("R4 second released", stage_adv[0], 1);
        flush();

        // R5: barrier keeps later ops in dispatch until it commits
        cyc(1, 4, 0, 1, 0);
        cyc(1, 0, 1, 1, 0);
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 1, 1, 0);
            chk("R5 op behind barrier held", stage_hold[0], 1);
            chk("R5 stage2 empty", stage_busy[2] & (stage_busy[3] ? 1 : 0) & stage_busy[1], 0);
        end
        cyc(0, 0, 1, 1, 1);
        chk("R5 barrier retires", stage_adv[3], 1);
        cyc(0, 0, 1, 1, 0);
        chk("R5 op released", stage_adv[0], 1);
        flush();

        // R6: commit on an empty writeback changes nothing
        cyc(0, 0, 1, 1, 1);
        chk("R6 commit empty busy", stage_busy, 0);
        chk("R6 commit empty adv", stage_adv[3], 0);

        // R8: full pipe with no commit holds every stage
        for (int i = 0; i < 8; i++) cyc(1, 0, 1, 1, 0);
        chk("R8 all held", stage_hold, 4'hF);
        chk("R8 no accept", issue_accept, 0);
        chk("R6 no commit no leave", stage_adv[3], 0);

        // R10: reset in the middle of traffic
        do_reset();

        // mixed traffic, compared against the model every cycle (R1..R9)
        for (int i = 0; i < 4000; i++)
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 4),
                $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                $urandom_range(0, 2) != 0);
        flush();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule